// File: doc/BRIEF.md
# Power Event Latch Controller

This block watches three asynchronous lines that can start a power cycle: a real-time-clock control line, an active-low control line from a management card, and the main power-good line. Each line goes through a synchronizer and an edge detector. The detected edge sets a sticky event latch, and the latch holds until a microcontroller reads it. Each line has its own edge rule. The clock line reacts to any transition. The management line and the power-good line react only to a high-to-low transition. For the power-good line, that transition means main power is failing.

A fourth, aggregate latch combines the three event latches into one active-low interrupt, `irq_n_o`. The microcontroller reads through a plain strobe-and-address port. Address 0 returns the event latches, the live synchronized levels of all three lines and the interrupt state, and a read there clears the event latches. Address 1 returns the interrupt state, and a read there releases the interrupt only if no event latch is set at that moment. The read port is plain control and status, so it has no back-pressure: a strobe is always accepted, and its data comes back exactly one cycle later.

Top module: `pwr_evt_ctrl`

## Requirements
- R1: Bits [5:3] of the address-0 word hold the synchronized live levels of the clock line, the management line and the power-good line, in that order. A pin change shows there on the third rising clock edge after it.
- R2: The clock-line latch, bit 0 of the address-0 word, sets on a rising transition of its input and also on a falling one.
- R3: The management-line latch, bit 1, sets on a high-to-low transition of `mgmt_ctl_n_i` only. A low-to-high transition leaves it clear.
- R4: The power-good latch, bit 2, sets on a high-to-low transition of `pwr_good_i` only. A low-to-high transition leaves it clear.
- R5: Once set, an event latch stays set when its input returns to the idle level, until a read at address 0.
- R6: A read strobe sampled at a clock edge gives `rd_valid_o` high and `rd_data_o` equal to the selected word during the next cycle. `rd_data_o` is zero in cycles with no read. The word returned is the value from before the clear. A read at address 0 clears all three event latches at that same edge.
- R7: If a qualifying edge reaches a latch at the same clock edge as an address-0 read, the latch ends that edge set.
- R8: `irq_n_o` goes low on the edge after any event latch becomes set, and stays low while any event latch is set. Bit 6 of the address-0 word and bit 0 of the address-1 word give the interrupt-pending state, active high.
- R9: A read at address 1 drives `irq_n_o` high at that edge only if all three event latches are clear. Otherwise `irq_n_o` stays low.
- R10: While `rst_n` is low and right after it rises, all latches are clear and `irq_n_o` is high. Input levels already present during reset are not taken as edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rtc_ctl_i | input | 1 | Real-time-clock control line, asynchronous |
| mgmt_ctl_n_i | input | 1 | Management-card control line, active low, asynchronous |
| pwr_good_i | input | 1 | Main power-good line, asynchronous |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | 1 | Word select: 0 event word, 1 interrupt word |
| rd_valid_o | output | 1 | High in the cycle after a read strobe |
| rd_data_o | output | 8 | Read data, valid with `rd_valid_o` |
| irq_n_o | output | 1 | Aggregate interrupt, active low |

## Verification
The assertions assume that the read strobe is synchronous to `clk` and that `rd_addr_i` is stable whenever the strobe is high. They also assume that each pin holds a new level for at least two clock cycles, so the synchronizer sees every change. The bench drives the strobe and the pins only on falling clock edges. It keeps every pin level for several cycles, so the stimulus stays within those assumptions. It also places one pin change so that its edge lands exactly on a read edge, to exercise the same-cycle case.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2
  } edge_mode_e;

  localparam int NUM_SRC   = 3;
  localparam int SRC_RTC   = 0;
  localparam int SRC_MGMT  = 1;
  localparam int SRC_PGOOD = 2;
  localparam int STATUS_W  = 8;

  localparam logic ADDR_EVT = 1'b0;
  localparam logic ADDR_IRQ = 1'b1;

  // Edge rule per source index
  function automatic edge_mode_e src_mode(input int idx);
    case (idx)
      SRC_RTC:  return EDGE_ANY;
      default:  return EDGE_FALL;
    endcase
  endfunction

endpackage

// File: rtl/pwr_evt_sync_edge.sv
module pwr_evt_sync_edge #(
  parameter int                      SYNC_STAGES = 2,
  parameter pwr_evt_pkg::edge_mode_e MODE        = pwr_evt_pkg::EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic event_o
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   hist_q;
  logic                   rise;
  logic                   fall;

  // Synchronizer keeps running in reset so history tracks real levels
  always_ff @(posedge clk) begin
    chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
    hist_q  <= chain_q[SYNC_STAGES-1];
  end

  assign level_o = chain_q[SYNC_STAGES-1];
  assign rise    = level_o & ~hist_q;
  assign fall    = ~level_o & hist_q;

  generate
    if (MODE == pwr_evt_pkg::EDGE_ANY) begin : g_any
      assign event_o = rst_n & (rise | fall);
    end else if (MODE == pwr_evt_pkg::EDGE_FALL) begin : g_fall
      assign event_o = rst_n & fall;
    end else begin : g_rise
      assign event_o = rst_n & rise;
    end
  endgenerate

endmodule

// File: rtl/pwr_evt_sticky.sv
module pwr_evt_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // A set on the clearing edge wins
  always_ff @(posedge clk) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= set_i | (q_o & ~clr_i);
  end
endmodule

// File: rtl/pwr_evt_irq_agg.sv
module pwr_evt_irq_agg #(
  parameter int NUM_SRC = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rd_i,
  output logic               pend_o,
  output logic               irq_n_o
);
  logic any_evt;
  assign any_evt = |evt_i;

  // Release only on a read while every event latch is clear
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= any_evt | (pend_o & ~rd_i);
  end

  assign irq_n_o = ~pend_o;
endmodule

// File: rtl/pwr_evt_ctrl.sv
module pwr_evt_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rtc_ctl_i,
  input  logic       mgmt_ctl_n_i,
  input  logic       pwr_good_i,
  input  logic       rd_en_i,
  input  logic       rd_addr_i,
  output logic       rd_valid_o,
  output logic [7:0] rd_data_o,
  output logic       irq_n_o
);
  import pwr_evt_pkg::*;

  localparam int PAD_W = STATUS_W - (2 * NUM_SRC) - 1;

  logic [NUM_SRC-1:0]  pin_vec;
  logic [NUM_SRC-1:0]  live_lvl;
  logic [NUM_SRC-1:0]  evt_pulse;
  logic [NUM_SRC-1:0]  evt_q;
  logic                clr_evt;
  logic                rd_irq;
  logic                irq_pend;
  logic [STATUS_W-1:0] word_evt;
  logic [STATUS_W-1:0] word_irq;

  assign pin_vec[SRC_RTC]   = rtc_ctl_i;
  assign pin_vec[SRC_MGMT]  = mgmt_ctl_n_i;
  assign pin_vec[SRC_PGOOD] = pwr_good_i;

  assign clr_evt = rd_en_i & (rd_addr_i == ADDR_EVT);
  assign rd_irq  = rd_en_i & (rd_addr_i == ADDR_IRQ);

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      pwr_evt_sync_edge #(
        .SYNC_STAGES (SYNC_STAGES),
        .MODE        (src_mode(g))
      ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_vec[g]),
        .level_o (live_lvl[g]),
        .event_o (evt_pulse[g])
      );

      pwr_evt_sticky u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_pulse[g]),
        .clr_i (clr_evt),
        .q_o   (evt_q[g])
      );
    end
  endgenerate

  pwr_evt_irq_agg #(
    .NUM_SRC (NUM_SRC)
  ) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (evt_q),
    .rd_i    (rd_irq),
    .pend_o  (irq_pend),
    .irq_n_o (irq_n_o)
  );

  assign word_evt = {{PAD_W{1'b0}}, irq_pend, live_lvl, evt_q};
  assign word_irq = {{(STATUS_W-1){1'b0}}, irq_pend};

  // Registered read: pre-clear values, one cycle after the strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (!rd_en_i)                    rd_data_o <= '0;
      else if (rd_addr_i == ADDR_EVT)  rd_data_o <= word_evt;
      else                             rd_data_o <= word_irq;
    end
  end

endmodule

// File: rtl/pwr_evt_ctrl_sva.sv
module pwr_evt_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en_i,
  input logic       rd_addr_i,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       irq_n_o,
  input logic [2:0] evt_q,
  input logic [2:0] evt_pulse
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (irq_n_o && evt_q == 3'b000 && !rd_valid_o)); // R10

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_i && rd_addr_i == 1'b0) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R5

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == 1'b0 && evt_pulse == 3'b000) |=> (evt_q == 3'b000)); // R6

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == 1'b0) |=> ((evt_q & $past(evt_pulse)) == $past(evt_pulse))); // R7

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~$past(evt_q) & ~$past(evt_pulse)) == 3'b000)); // R2

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q != 3'b000) |=> !irq_n_o); // R8

  AST_IRQ_HOLD_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i == 1'b1 && evt_q != 3'b000) |=> !irq_n_o); // R9

  AST_READ_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o); // R6

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> (rd_data_o == 8'h00)); // R6

endmodule

bind pwr_evt_ctrl pwr_evt_ctrl_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .irq_n_o    (irq_n_o),
  .evt_q      (evt_q),
  .evt_pulse  (evt_pulse)
);

// File: tb/pwr_evt_ctrl_tb.sv
module pwr_evt_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rtc = 1'b1;
  logic       mgmt_n = 1'b1;
  logic       pgood = 1'b1;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwr_evt_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rtc_ctl_i    (rtc),
    .mgmt_ctl_n_i (mgmt_n),
    .pwr_good_i   (pgood),
    .rd_en_i      (rd_en),
    .rd_addr_i    (rd_addr),
    .rd_valid_o   (rd_valid),
    .rd_data_o    (rd_data),
    .irq_n_o      (irq_n)
  );

  // Behavioural reference: pin history queues, integer latch state
  bit   pin_q[3][$];
  int   m_lat[3];
  int   m_pend = 0;
  int   m_vld = 0;
  int   m_data = 0;

  initial begin
    for (int i = 0; i < 3; i++) begin
      pin_q[i] = '{0, 0, 0};
      m_lat[i] = 0;
    end
  end

  function automatic int cur_pin(input int i);
    case (i)
      0: return int'(rtc);
      1: return int'(mgmt_n);
      default: return int'(pgood);
    endcase
  endfunction

  always @(posedge clk) begin
    int lvl[3];
    int prev[3];
    int ev[3];
    int any_lat;
    int word;
    any_lat = 0;
    word = 0;
    for (int i = 0; i < 3; i++) begin
      lvl[i]  = int'(pin_q[i][1]);
      prev[i] = int'(pin_q[i][2]);
      if (m_lat[i] != 0) any_lat = 1;
    end
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_lat[i] = 0;
      m_pend = 0; m_vld = 0; m_data = 0;
    end else begin
      ev[0] = (lvl[0] != prev[0]) ? 1 : 0;
      ev[1] = (prev[1] == 1 && lvl[1] == 0) ? 1 : 0;
      ev[2] = (prev[2] == 1 && lvl[2] == 0) ? 1 : 0;
      if (rd_en && rd_addr == 1'b0) begin
        word = m_pend * 64;
        for (int i = 0; i < 3; i++) word += m_lat[i] * (1 << i) + lvl[i] * (8 << i);
      end else if (rd_en) begin
        word = m_pend;
      end
      m_data = word;
      m_vld  = rd_en ? 1 : 0;
      m_pend = (any_lat != 0 || (m_pend != 0 && !(rd_en && rd_addr == 1'b1))) ? 1 : 0;
      for (int i = 0; i < 3; i++) begin
        if (ev[i] != 0) m_lat[i] = 1;
        else if (rd_en && rd_addr == 1'b0) m_lat[i] = 0;
      end
    end
    for (int i = 0; i < 3; i++) begin
      pin_q[i].push_front(cur_pin(i) != 0);
      void'(pin_q[i].pop_back());
    end
  end

  // Compare the model with the ports on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (int'(irq_n) != (1 - m_pend)) begin
        errors++;
        $display("FAIL R8 R9 model irq_n actual %0d expected %0d at %0t", irq_n, 1 - m_pend, $time);
      end
      checks++;
      if (int'(rd_valid) != m_vld || int'(rd_data) != m_data) begin
        errors++;
        $display("FAIL R6 model read actual %0d/%02h expected %0d/%02h at %0t",
                 rd_valid, rd_data, m_vld, m_data, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic a, output logic [7:0] d);
    rd_en = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    rd_addr = 1'b0;
    d = rd_data;
  endtask

  initial begin
    logic [7:0] d;
    @(negedge clk);
    cycles(4);
    rtc = 1'b0;
    cycles(5);
    rst_n = 1'b1;
    cycles(4);
    check("R10 irq idle after reset", int'(irq_n), 1);
    do_read(1'b0, d);
    check("R10 no false edge from reset levels", int'(d[2:0]), 0);
    check("R1 live levels after reset", int'(d[5:3]), 3'b110);

    // R2 rising edge on clock line
    rtc = 1'b1;
    cycles(4);
    check("R8 irq low after event", int'(irq_n), 0);
    do_read(1'b0, d);
    check("R2 rising sets latch", int'(d[2:0]), 3'b001);
    check("R1 live clock level", int'(d[3]), 1);
    check("R8 pending bit in event word", int'(d[6]), 1);
    do_read(1'b0, d);
    check("R6 latch cleared by read", int'(d[2:0]), 0);
    do_read(1'b1, d);
    check("R9 irq word pending", int'(d[0]), 1);
    check("R9 irq released with latches clear", int'(irq_n), 1);

    // R2 falling edge
    rtc = 1'b0;
    cycles(4);
    do_read(1'b0, d);
    check("R2 falling sets latch", int'(d[2:0]), 3'b001);
    do_read(1'b1, d);

    // R3 falling sets, rising ignored
    mgmt_n = 1'b0;
    cycles(4);
    do_read(1'b0, d);
    check("R3 falling sets latch", int'(d[2:0]), 3'b010);
    mgmt_n = 1'b1;
    cycles(4);
    do_read(1'b0, d);
    check("R3 rising ignored", int'(d[2:0]), 0);
    do_read(1'b1, d);
    check("R3 irq released", int'(irq_n), 1);

    // R4 rising ignored on power-good, then R5 sticky after a falling pulse
    pgood = 1'b0;
    cycles(4);
    do_read(1'b0, d);
    check("R4 falling sets latch", int'(d[2:0]), 3'b100);
    do_read(1'b1, d);
    pgood = 1'b1;
    cycles(4);
    check("R4 rising leaves irq high", int'(irq_n), 1);
    do_read(1'b0, d);
    check("R4 rising ignored", int'(d[2:0]), 0);
    pgood = 1'b0;
    cycles(3);
    pgood = 1'b1;
    cycles(10);
    do_read(1'b1, d);
    check("R9 irq held while latch set", int'(irq_n), 0);
    do_read(1'b0, d);
    check("R5 latch holds after input recovers", int'(d[2:0]), 3'b100);
    check("R1 live power-good level", int'(d[5]), 1);
    do_read(1'b1, d);
    check("R9 irq released after clear", int'(irq_n), 1);

    // R7 edge lands on the clearing read edge
    mgmt_n = 1'b0;
    cycles(2);
    do_read(1'b0, d);
    check("R7 read returns pre-set value", int'(d[1]), 0);
    do_read(1'b0, d);
    check("R7 coincident edge kept", int'(d[2:0]), 3'b010);
    do_read(1'b1, d);
    cycles(3);
    check("R6 no read gives zero data", int'(rd_data), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule